// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block carries out one element-wise vector operation at a time over a register of `NELEM` elements, each `EW` bits wide. Control comes from a per-element mask register held inside the block. Three operations write the mask: a signed greater-or-equal compare of A against B, a test for zero on A, and a complement. Four operations produce element results: add, multiply, move A and move B. A result leaves the block on a write port, and its write enable is gated by the mask bit of that element.

The data operations run in one of two modes, chosen per operation. In simple mode the sequencer steps through every element below the vector length, one per cycle. It presents each result and raises the write enable only where the mask bit is set. In density mode the sequencer scans the mask and issues only the set elements below the length, so the run takes as many cycles as there are active elements. A masked select such as an element-wise maximum uses a sequence of four operations: compare, move A, complement, move B.

The operand vectors are read live, so the caller holds `vec_a` and `vec_b` steady from the start pulse until `done`. Elements are numbered from 0, and element i occupies bits `[i*EW +: EW]` of each operand bus.

Top module: `mvec_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `wr_en` are low and every mask bit is 0.
- R2: Operation code 4 sets mask bit i to 1 when signed A[i] >= signed B[i] and i is below the effective length, and clears every bit at or above that length. For A = {1,2,3,4,-5,0,6,-7} and B = {2,2,2,10,-4,-3,5,-8} at length 8, the mask is 8'b11100110, with bit i belonging to element i.
- R3: Operation code 5 sets mask bit i to 1 when A[i] equals zero and i is below the effective length, and clears every other bit.
- R4: Operation code 6 inverts every mask bit below the effective length and clears the bits at or above it. Codes 4, 5, 6 and 7 complete with `done` in the cycle after the start edge and make no write. Code 7 leaves the mask unchanged.
- R5: In simple mode (`dense` = 0), the cycle after the start edge presents element 0, and each following cycle presents the next element up to length-1. `wr_idx` equals the element number and `wr_en` equals that element's mask bit. `done` is high for one cycle, in the cycle after the last element.
- R6: In density mode (`dense` = 1), only elements below the length whose mask bit is 1 are presented, in ascending order, one per cycle with `wr_en` high. `done` follows in the cycle after the last of them, or in the cycle right after the start edge when there are none.
- R7: Data codes produce `wr_data`: 0 gives the low EW bits of A[i]+B[i], 1 the low EW bits of A[i]*B[i], 2 gives A[i] and 3 gives B[i].
- R8: A `start` pulse while `busy` is high is ignored. It changes neither the running sequence nor the mask.
- R9: A length above `NELEM` acts as `NELEM`. A length of 0 makes a data operation finish in the cycle after the start edge with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| op | input | 3 | Operation code (0..7) |
| dense | input | 1 | 1 selects density mode, 0 simple mode |
| vlen | input | $clog2(NELEM+1) | Vector length for this operation |
| vec_a | input | NELEM*EW | Operand vector A, element i at [i*EW +: EW] |
| vec_b | input | NELEM*EW | Operand vector B |
| busy | output | 1 | A data operation is being sequenced |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write enable for the presented element |
| wr_idx | output | $clog2(NELEM) | Number of the presented element |
| wr_data | output | EW | Result for the presented element |
| mask_q | output | NELEM | Current mask register |

## Verification
The bench sweeps the lengths 0, 1, 3, 5, 8, 9 and 15 across every data code in both modes, using masks from both compares and from the complement. This catches a scanner that issues an element at or past the length, and a length clamp that lets the sequence run beyond the register. It also catches a zero-active or zero-length run that hangs or sends out a stray write. Cycle counts are checked exactly, so a `done` that comes one cycle late after the final active element shows up. Signed compares with negative operands expose an unsigned comparator. The max sequence shows whether the complement touches bits beyond the length. A start pulse during a run checks that a busy unit neither restarts nor rewrites its mask.

// File: rtl/mvec_pkg.sv
package mvec_pkg;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_MUL    = 3'd1,
        OP_MOVA   = 3'd2,
        OP_MOVB   = 3'd3,
        OP_CMPGE  = 3'd4,
        OP_CMPEQZ = 3'd5,
        OP_INV    = 3'd6,
        OP_NOP    = 3'd7
    } vop_e;

    typedef struct packed {
        logic run;
        logic dense;
        vop_e op;
    } seq_ctl_t;

    function automatic logic is_mask_op(vop_e o);
        return o[2];
    endfunction

endpackage

// File: rtl/mvec_alu.sv
module mvec_alu
    import mvec_pkg::*;
#(
    parameter int EW = 32
) (
    input  vop_e          op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] res
);
    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_MUL:  res = a * b;
            OP_MOVA: res = a;
            OP_MOVB: res = b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/mvec_scan.sv
module mvec_scan #(
    parameter int NELEM = 8,
    parameter int IW    = 4
) (
    input  logic [NELEM-1:0] bits,
    input  logic [IW-1:0]    from,
    output logic             found,
    output logic [IW-1:0]    pos,
    output logic             more
);
    logic [NELEM-1:0] cand;

    always_comb begin
        cand  = bits & ({NELEM{1'b1}} << from);
        found = |cand;
        pos   = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (cand[i]) pos = IW'(i);
        end
        more = |(cand & (cand - NELEM'(1)));
    end
endmodule

// File: rtl/mvec_mask.sv
module mvec_mask
    import mvec_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 32,
    parameter int IW    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  vop_e                op,
    input  logic [IW-1:0]       vlen_eff,
    input  logic [NELEM*EW-1:0] vec_a,
    input  logic [NELEM*EW-1:0] vec_b,
    output logic [NELEM-1:0]    mask_q
);
    logic [NELEM-1:0] ge_bits, z_bits, in_len, nxt;

    generate
        for (genvar g = 0; g < NELEM; g++) begin : g_el
            logic signed [EW-1:0] ea, eb;
            assign ea        = vec_a[g*EW +: EW];
            assign eb        = vec_b[g*EW +: EW];
            assign ge_bits[g] = ea >= eb;
            assign z_bits[g]  = ea == '0;
            assign in_len[g]  = IW'(g) < vlen_eff;
        end
    endgenerate

    always_comb begin
        case (op)
            OP_CMPGE:  nxt = ge_bits & in_len;
            OP_CMPEQZ: nxt = z_bits & in_len;
            OP_INV:    nxt = ~mask_q & in_len;
            default:   nxt = mask_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      mask_q <= '0;
        else if (upd) mask_q <= nxt;
    end

    // R2 R3 R4: a mask write never leaves a bit set at or above the length
    assert_len_clear_R4: assert property (@(posedge clk) disable iff (rst)
        upd && (op != OP_NOP) |=> ((mask_q >> $past(vlen_eff)) == '0));
endmodule

// File: rtl/mvec_unit.sv
module mvec_unit
    import mvec_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 32,
    localparam int IW   = $clog2(NELEM + 1),
    localparam int XW   = $clog2(NELEM),
    localparam int VW   = NELEM * EW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic          dense,
    input  logic [IW-1:0] vlen,
    input  logic [VW-1:0] vec_a,
    input  logic [VW-1:0] vec_b,
    output logic          busy,
    output logic          done,
    output logic [0:0]    wr_en,
    output logic [XW-1:0] wr_idx,
    output logic [EW-1:0] wr_data,
    output logic [NELEM-1:0] mask_q
);
    seq_ctl_t      ctl_q;
    logic [IW-1:0] cur_q, vlen_q, vlen_eff;
    logic          done_q, accept;
    vop_e          op_in;
    logic [NELEM-1:0] lm_in, lm_q, eff_in, eff_q;
    logic          s_found, s_more;
    logic [IW-1:0] s_pos, idx_sel;
    logic [XW-1:0] xidx;

    assign op_in    = vop_e'(op);
    assign accept   = start && !ctl_q.run;
    assign vlen_eff = (vlen > IW'(NELEM)) ? IW'(NELEM) : vlen;

    always_comb begin
        for (int i = 0; i < NELEM; i++) begin
            lm_in[i] = IW'(i) < vlen_eff;
            lm_q[i]  = IW'(i) < vlen_q;
        end
        eff_in = mask_q & lm_in;
        eff_q  = mask_q & lm_q;
    end

    mvec_mask #(.NELEM(NELEM), .EW(EW), .IW(IW)) u_mask (
        .clk(clk), .rst(rst),
        .upd(accept && is_mask_op(op_in)),
        .op(op_in), .vlen_eff(vlen_eff),
        .vec_a(vec_a), .vec_b(vec_b), .mask_q(mask_q)
    );

    mvec_scan #(.NELEM(NELEM), .IW(IW)) u_scan (
        .bits(eff_q), .from(cur_q),
        .found(s_found), .pos(s_pos), .more(s_more)
    );

    assign idx_sel = ctl_q.dense ? s_pos : cur_q;
    assign xidx    = idx_sel[XW-1:0];

    mvec_alu #(.EW(EW)) u_alu (
        .op(ctl_q.op),
        .a(vec_a[xidx*EW +: EW]),
        .b(vec_b[xidx*EW +: EW]),
        .res(wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{run: 1'b0, dense: 1'b0, op: OP_ADD};
            cur_q  <= '0;
            vlen_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                ctl_q.op    <= op_in;
                ctl_q.dense <= dense;
                vlen_q      <= vlen_eff;
                cur_q       <= '0;
                if (is_mask_op(op_in))
                    done_q <= 1'b1;
                else if (dense ? (eff_in == '0) : (vlen_eff == '0))
                    done_q <= 1'b1;
                else
                    ctl_q.run <= 1'b1;
            end else if (ctl_q.run) begin
                if (ctl_q.dense) begin
                    cur_q <= s_pos + IW'(1);
                    if (!s_more) begin
                        ctl_q.run <= 1'b0;
                        done_q    <= 1'b1;
                    end
                end else begin
                    cur_q <= cur_q + IW'(1);
                    if (cur_q == vlen_q - IW'(1)) begin
                        ctl_q.run <= 1'b0;
                        done_q    <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy   = ctl_q.run;
    assign done   = done_q;
    assign wr_idx = xidx;
    assign wr_en  = ctl_q.run && (ctl_q.dense ? s_found : mask_q[xidx]);

    // R5 R6: a write only hits an element that is active and inside the length
    assert_wr_masked_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (mask_q[wr_idx] && (IW'(wr_idx) < vlen_q)));
    // R6: density mode issues an element in every busy cycle
    assert_dense_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && ctl_q.dense) |-> wr_en);
    // R5: completion never overlaps a running sequence
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R5 R6: consecutive writes go to ascending elements
    assert_ascend_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_idx > $past(wr_idx)));
    // R8: mask holds while a run is busy, even under a new start
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mask_q));
endmodule

// File: tb/mvec_unit_test.sv
module mvec_unit_test;
    localparam int N  = 8;
    localparam int EW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] op = 3'd0;
    logic dense = 1'b0;
    logic [3:0] vlen = 4'd0;
    logic [N*EW-1:0] vec_a, vec_b;
    logic busy, done;
    logic [0:0] wr_en;
    logic [2:0] wr_idx;
    logic [EW-1:0] wr_data;
    logic [N-1:0] mask_q;

    logic [EW-1:0] av [N];
    logic [EW-1:0] bv [N];
    logic [EW-1:0] res [N];
    logic [N-1:0] m;
    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            vec_a[i*EW +: EW] = av[i];
            vec_b[i*EW +: EW] = bv[i];
        end
    end

    mvec_unit #(.NELEM(N), .EW(EW)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .dense(dense),
        .vlen(vlen), .vec_a(vec_a), .vec_b(vec_b), .busy(busy),
        .done(done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mask_q(mask_q)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] exp_data(input int o, input logic [EW-1:0] a,
                                               input logic [EW-1:0] b);
        case (o)
            0: return a + b;
            1: return a * b;
            2: return a;
            default: return b;
        endcase
    endfunction

    task automatic go(input int o, input bit d, input int vl, input bit poke);
        int ve, expn, ptr, got;
        string tg;
        ve  = (vl > N) ? N : vl;
        tg  = (vl == 0 || vl > N) ? "R9" : (d ? "R6" : "R5");
        @(negedge clk);
        op = o[2:0]; dense = d; vlen = vl[3:0]; start = 1'b1;
        @(posedge clk);
        // bench model of the mask (R2 R3 R4)
        if (o == 4)
            for (int i = 0; i < N; i++) m[i] = (i < ve) && ($signed(av[i]) >= $signed(bv[i]));
        else if (o == 5)
            for (int i = 0; i < N; i++) m[i] = (i < ve) && (av[i] == 0);
        else if (o == 6)
            for (int i = 0; i < N; i++) m[i] = (i < ve) ? ~m[i] : 1'b0;
        @(negedge clk);
        start = 1'b0;
        expn = 0;
        if (o < 4) begin
            if (!d) expn = ve;
            else for (int i = 0; i < ve; i++) if (m[i]) expn++;
        end
        ptr = 0;
        got = -1;
        for (int c = 0; c < 40; c++) begin
            start = 1'b0;
            if (done) begin got = c; break; end
            if (poke && c == 1) begin start = 1'b1; op = 3'd6; end
            if (!d) begin
                check(wr_idx == c[2:0], {tg, " index"}, 32'(wr_idx), c);
                check(wr_en == m[c], {tg, " enable"}, 32'(wr_en), 32'(m[c]));
            end else begin
                while (ptr < ve && !m[ptr]) ptr++;
                check(wr_en == 1'b1 && wr_idx == ptr[2:0], {tg, " dense index"},
                      32'(wr_idx), ptr);
                ptr++;
            end
            if (wr_en) begin
                check(wr_data == exp_data(o, av[wr_idx], bv[wr_idx]), "R7 data",
                      wr_data, exp_data(o, av[wr_idx], bv[wr_idx]));
                res[wr_idx] = wr_data;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(got == expn, {tg, " cycles to done"}, got, expn);
        if (o >= 4)
            check(mask_q == m, (o == 4) ? "R2 mask" : (o == 5) ? "R3 mask" : "R4 mask",
                  32'(mask_q), 32'(m));
        if (poke) check(mask_q == m, "R8 mask kept", 32'(mask_q), 32'(m));
        @(negedge clk);
        check(done == 1'b0, "R5 done pulse width", 32'(done), 0);
    endtask

    task automatic load(input int kind);
        if (kind == 0) begin
            av = '{32'd1, 32'd2, 32'd3, 32'd4, -32'sd5, 32'd0, 32'd6, -32'sd7};
            bv = '{32'd2, 32'd2, 32'd2, 32'd10, -32'sd4, -32'sd3, 32'd5, -32'sd8};
        end else begin
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                av[i] = (i % 3 == kind % 3) ? 32'd0 : lfsr;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                bv[i] = (i % 4 == kind % 4) ? av[i] : lfsr;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                $display("FAIL watchdog: actual=%0d expected=finish", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int lens [7];
        lens = '{0, 1, 3, 5, 8, 9, 15};
        m = '0;
        load(0);
        for (int i = 0; i < N; i++) res[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && wr_en == 0, "R1 idle outputs",
              {29'd0, busy, done, wr_en}, 0);
        check(mask_q == '0, "R1 mask cleared", 32'(mask_q), 0);

        // worked compare example (R2)
        go(4, 0, 8, 0);
        check(mask_q == 8'b11100110, "R2 example mask", 32'(mask_q), 32'h0E6);
        // element-wise maximum through masked moves
        go(2, 1, 8, 0);
        go(6, 0, 8, 0);
        go(3, 1, 8, 0);
        for (int i = 0; i < N; i++)
            check(res[i] == (($signed(av[i]) >= $signed(bv[i])) ? av[i] : bv[i]),
                  "R4 max sequence", res[i], av[i]);

        // sweep of lengths, modes and codes
        for (int k = 0; k < 4; k++) begin
            load(k);
            for (int li = 0; li < 7; li++) begin
                go((li % 2 == 0) ? 4 : 5, 0, lens[li], 0);
                for (int o = 0; o < 4; o++) begin
                    go(o, 0, lens[li], 0);
                    go(o, 1, lens[li], 0);
                end
                go(6, 0, lens[li], 0);
                go(0, 1, lens[li], 0);
                go(7, 0, lens[li], 0);
                go(1, 0, lens[li], 0);
            end
        end

        // start while busy is ignored (R8)
        load(0);
        go(4, 0, 8, 0);
        go(0, 0, 8, 1);
        go(2, 1, 8, 1);
        go(6, 1, 8, 0);
        go(1, 1, 8, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule